// File: doc/BRIEF.md
# Serial Bootstrap RAM Loader

This block runs once after reset when the bootstrap strap is set. It takes bytes from a UART receiver's byte-valid interface and writes them into on-chip RAM one after another, starting at address zero. It stops in one of two ways, whichever comes first. The first is writing the byte for the highest RAM address. The second is the receive stream going quiet for four character times after at least one byte has arrived. It then raises a sticky completion flag and presents an execution start address of zero, which hands control to the loaded program.

If the strap is clear when reset is released, the loader goes inert and touches nothing. The block also turns the transmit bit into an open-drain pad enable, so the pad is only ever pulled low or released.

Top module: `boot_ram_loader`

## Requirements
- R1: The strap is sampled on the first clock edge after reset is released. If it is clear, `ram_we`, `done` and `boot_active` stay low until the next reset, whatever arrives on the receive port. Changes of the strap after that edge have no effect.
- R2: Each byte with `rx_valid` high on a clock edge, while loading, gives exactly one `ram_we` pulse one clock long in the following cycle. During that pulse `ram_addr` and `ram_wdata` are valid. The first byte goes to address 0 and each later byte to the next higher address.
- R3: No write ever targets an address above the top RAM address (2^ADDR_W-1). Bytes that arrive after completion produce no write.
- R4: The write strobe for the top RAM address is accompanied in the same cycle by `done` going high.
- R5: After a byte has been accepted, `done` rises after exactly IDLE_CHARS*CHAR_CLKS consecutive clock edges with `rx_valid` low. Any accepted byte restarts that count, so a gap one edge shorter does not end the download.
- R6: Before the first byte arrives, no timeout runs. The loader waits with `done` low for as long as needed.
- R7: `done` stays high from completion until reset. `exec_addr` is always 0, and `boot_active` is high only while loading is in progress.
- R8: `tx_pad_oe` is high exactly when `tx_bit` is 0, so the transmit pad is only driven low or left released.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| boot_strap | input | 1 | Bootstrap mode select, sampled after reset |
| rx_valid | input | 1 | One-cycle pulse per received byte |
| rx_data | input | 8 | Received byte |
| tx_bit | input | 1 | Serial transmit bit from the UART |
| ram_we | output | 1 | RAM write strobe, one clock per byte |
| ram_addr | output | ADDR_W | RAM write address |
| ram_wdata | output | 8 | RAM write data |
| boot_active | output | 1 | Download in progress |
| done | output | 1 | Download finished, sticky until reset |
| exec_addr | output | ADDR_W | Start address for the loaded program (zero) |
| tx_pad_oe | output | 1 | Pull-low enable for the open-drain transmit pad |

## Verification
The bench goes after the exact length of the quiet window. A gap one edge shorter than the timeout must keep the download open, and the full gap must end it on the precise edge. A counter that is off by one would raise `done` one cycle early or late, or end a download that was still running. It fills every RAM location with back-to-back bytes and then keeps sending. A loader with a wrapping or unguarded pointer would then overwrite address 0 or miss the completion that goes with the top write. It also holds the loader unfed for a long stretch, and flips the strap after it has been sampled. A design that started its timer at reset would finish with nothing loaded, and one that re-read the strap would wake up in a normal boot.

// File: rtl/boot_ram_loader.sv
module boot_ram_loader #(
  parameter int ADDR_W     = 6,
  parameter int CHAR_CLKS  = 10,
  parameter int IDLE_CHARS = 4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              boot_strap,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  input  logic              tx_bit,
  output logic              ram_we,
  output logic [ADDR_W-1:0] ram_addr,
  output logic [7:0]        ram_wdata,
  output logic              boot_active,
  output logic              done,
  output logic [ADDR_W-1:0] exec_addr,
  output logic              tx_pad_oe
);
  localparam int TIMEOUT = CHAR_CLKS * IDLE_CHARS;
  localparam int IW = $clog2(TIMEOUT + 1);
  localparam logic [ADDR_W-1:0] TOP = '1;
  localparam logic [IW-1:0] IDLE_LAST = IW'(TIMEOUT - 1);

  typedef enum logic [1:0] {S_SAMPLE, S_LOAD, S_OFF, S_DONE} st_t;

  st_t               st;
  logic [ADDR_W-1:0] wptr;
  logic [IW-1:0]     idle;
  logic              got_byte;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st        <= S_SAMPLE;
      wptr      <= '0;
      idle      <= '0;
      got_byte  <= 1'b0;
      ram_we    <= 1'b0;
      ram_addr  <= '0;
      ram_wdata <= '0;
    end else begin
      ram_we <= 1'b0;
      case (st)
        S_SAMPLE: st <= boot_strap ? S_LOAD : S_OFF;
        S_LOAD: begin
          if (rx_valid) begin
            ram_we    <= 1'b1;
            ram_addr  <= wptr;
            ram_wdata <= rx_data;
            wptr      <= wptr + 1'b1;
            idle      <= '0;
            got_byte  <= 1'b1;
            if (wptr == TOP) st <= S_DONE;
          end else if (got_byte) begin
            if (idle == IDLE_LAST) st <= S_DONE;
            else idle <= idle + 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  assign done        = (st == S_DONE);
  assign boot_active = (st == S_LOAD);
  assign exec_addr   = '0;
  assign tx_pad_oe   = ~tx_bit;

  // R1
  we_needs_boot_chk: assert property (@(posedge clk) disable iff (!rst_n)
    ram_we |-> (boot_active || done));
  // R3
  no_write_after_done_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !ram_we);
  // R4
  top_write_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr == TOP) |-> done);
  // R2
  mid_write_open_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (ram_we && ram_addr != TOP) |-> !done);
  // R6
  no_early_timeout_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !got_byte |-> !done);
  // R7
  done_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> done);
endmodule

// File: tb/tb_boot_ram_loader.sv
module tb_boot_ram_loader;
  localparam int AW = 6;
  localparam int CC = 10;
  localparam int IC = 4;
  localparam int T = CC * IC;
  localparam int DEPTH = 1 << AW;

  logic clk = 0, rst_n = 0, boot_strap = 0, rx_valid = 0, tx_bit = 1;
  logic [7:0] rx_data = 0;
  logic ram_we, boot_active, done, tx_pad_oe;
  logic [AW-1:0] ram_addr, exec_addr;
  logic [7:0] ram_wdata;

  boot_ram_loader #(.ADDR_W(AW), .CHAR_CLKS(CC), .IDLE_CHARS(IC)) dut (
    .clk(clk), .rst_n(rst_n), .boot_strap(boot_strap), .rx_valid(rx_valid),
    .rx_data(rx_data), .tx_bit(tx_bit), .ram_we(ram_we), .ram_addr(ram_addr),
    .ram_wdata(ram_wdata), .boot_active(boot_active), .done(done),
    .exec_addr(exec_addr), .tx_pad_oe(tx_pad_oe));

  always #10 clk = ~clk;

  int errors = 0, checks = 0;
  bit finished = 0;

  // behavioural reference: phase 0 sample, 1 load, 2 off
  int m_phase, m_next, m_quiet;
  bit m_seen, m_done, m_we;
  int m_addr, m_data;
  logic [7:0] ram_img [DEPTH];

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_phase = 0; m_next = 0; m_quiet = 0; m_seen = 0; m_done = 0;
      m_we = 0; m_addr = 0; m_data = 0;
    end else begin
      m_we = 0;
      if (m_phase == 0) m_phase = boot_strap ? 1 : 2;
      else if (m_phase == 1 && !m_done) begin
        if (rx_valid) begin
          m_we = 1; m_addr = m_next; m_data = rx_data;
          if (m_next == DEPTH - 1) m_done = 1;
          m_next++; m_quiet = 0; m_seen = 1;
        end else if (m_seen) begin
          m_quiet++;
          if (m_quiet == T) m_done = 1;
        end
      end
    end
  end

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) if (rst_n) begin
    chk(ram_we === m_we, "R2 ram_we", ram_we, m_we);
    if (m_we) begin
      chk(ram_addr === AW'(m_addr), "R2 ram_addr", ram_addr, m_addr);
      chk(ram_wdata === 8'(m_data), "R2 ram_wdata", ram_wdata, m_data);
      ram_img[ram_addr] = ram_wdata;
    end
    chk(done === m_done, "R4/R5 done", done, m_done);
    chk(boot_active === (m_phase == 1 && !m_done), "R7 boot_active", boot_active, m_phase == 1 && !m_done);
  end

  task automatic do_reset(input bit strap);
    rst_n = 0; rx_valid = 0; boot_strap = strap;
    repeat (2) @(negedge clk);
    rst_n = 1;
    @(negedge clk);
  endtask

  task automatic send(input logic [7:0] d, input int gap);
    rx_valid = 1; rx_data = d;
    @(negedge clk);
    rx_valid = 0;
    repeat (gap) @(negedge clk);
  endtask

  initial begin
    #(200000 * 20);
    if (!finished) begin
      errors++; checks++;
      $display("FAIL watchdog actual=1 expected=0");
      $display("Result: errors=%0d of %0d checks", errors, checks);
      $finish;
    end
  end

  initial begin
    // reset state
    rst_n = 0; boot_strap = 1;
    #5;
    chk(ram_we === 0 && done === 0 && boot_active === 0, "R1 reset state", done, 0);
    // R8 open-drain transmit
    tx_bit = 0; #1; chk(tx_pad_oe === 1, "R8 tx low", tx_pad_oe, 1);
    tx_bit = 1; #1; chk(tx_pad_oe === 0, "R8 tx released", tx_pad_oe, 0);

    // R1: strap clear, later set, bytes ignored
    do_reset(0);
    boot_strap = 1;
    for (int i = 0; i < 5; i++) send(8'(i + 1), 2);
    repeat (T + 5) @(negedge clk);
    chk(done === 0 && boot_active === 0, "R1 normal boot stays idle", done, 0);

    // R6: long wait without bytes, strap flipped after sampling
    do_reset(1);
    boot_strap = 0;
    repeat (3 * T) @(negedge clk);
    chk(done === 0 && boot_active === 1, "R6 waits for first byte", done, 0);
    chk(exec_addr === 0, "R7 exec_addr zero", exec_addr, 0);

    // R5: gaps up to T-1 keep download open, then exact timeout
    send(8'hA5, 0);
    send(8'h5A, 3);
    send(8'h3C, T - 1);
    chk(done === 0, "R5 gap of T-1 keeps loading", done, 0);
    send(8'hC3, 0);
    begin
      int k = 0;
      while (!done && k < 4 * T) begin @(negedge clk); k++; end
      chk(k == T, "R5 timeout edge count", k, T);
    end
    chk(ram_img[0] === 8'hA5 && ram_img[3] === 8'hC3, "R2 order from zero", ram_img[3], 8'hC3);
    send(8'h77, 2);
    chk(done === 1 && ram_img[4] !== 8'h77, "R3 byte after timeout ignored", done, 1);
    chk(exec_addr === 0, "R7 exec_addr at done", exec_addr, 0);

    // R3/R4: full fill, back-to-back, then extras
    do_reset(1);
    for (int i = 0; i < DEPTH; i++) send(8'(i * 7 + 3), 0);
    chk(done === 1, "R4 done on top write", done, 1);
    for (int i = 0; i < 4; i++) send(8'hEE, 1);
    chk(ram_img[0] === 8'd3, "R3 no wrap to address 0", ram_img[0], 3);
    begin
      int bad = 0;
      for (int i = 0; i < DEPTH; i++) if (ram_img[i] !== 8'(i * 7 + 3)) bad++;
      chk(bad == 0, "R2 full image", bad, 0);
    end
    repeat (2 * T) @(negedge clk);
    chk(done === 1, "R7 done sticky", done, 1);

    finished = 1;
    $display("Result: errors=%0d of %0d checks", errors, checks);
    $finish;
  end
endmodule